// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Emulator

This block stands in for a byte-wide, one-time-programmable memory that is controlled by two lines: a chip select and an output gate. Four inputs set the operating mode. Two of them are active-low strobes. The other two are single-bit flags that model high-voltage conditions: one on the output-gate/programming pin and one on address line 9. From these inputs the block runs a normal read, deselect (standby), program, program-inhibit, verify (a normal read after programming) or identification read. The data output comes with its own drive-enable, so a pad ring or bus multiplexer can build a tri-state bus from the pair.

Every stored bit starts at one. A program cycle can only clear bits, so the stored word becomes the old word ANDed with the input byte. The identification read gives a manufacturer byte, a device byte or a continuation byte, depending on address lines 0 and 1. Bit 7 of each identifier is an odd-parity bit that the logic computes. Analog access delays are modelled as clock-cycle counts. One count runs from the later of an address change or chip select falling. A second, shorter count runs from the output gate falling. The depth is a parameter: the full device uses 16 address bits, and the default is 11 to keep elaboration small.

Top module: `otp_emu`

## Requirements
- R1: After reset every word reads 0xFF.
- R2: `dout_en` is high only while `ce_n` is low, `oe_n` is low and `vpp_hi` is low. With `ce_n` high it stays low whatever `oe_n` is.
- R3: On each clock edge where `vpp_hi` is high and `ce_n` is low, the addressed word becomes its old value ANDed with `din`.
- R4: With `vpp_hi` high and `ce_n` high, no word changes.
- R5: Programming never turns a stored zero back into a one. A second program of the same word ANDs again.
- R6: In an identification read (`id_hi` high) with address bit 1 set, address bit 0 low gives the manufacturer byte and address bit 0 high gives the device byte.
- R7: In an identification read with address bit 1 clear, the output is 0x7F.
- R8: Bit 7 of each identifier byte is set so that the whole byte has an odd number of ones. Bits 6:0 are the parameters `MFR_BASE` and `DEV_BASE`.
- R9: In an identification read, any nonzero address bit other than bits 0, 1 and 9 gives 0xFF. Bit 9 is ignored.
- R10: Take the clock edge that first samples a new address (or a new `id_hi`) or a falling `ce_n` as the first edge. `dout_en` rises after edge `ACC_CYC`, provided the output gate is already settled.
- R11: Take the edge that first samples `oe_n` low as the first edge. `dout_en` rises after edge `OE_CYC`, provided address access is already settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; erases the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming-voltage flag on the output-gate pin |
| id_hi | input | 1 | Identification-voltage flag on address bit 9 |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, valid while `dout_en` is high |
| dout_en | output | 1 | Output drive enable for the tri-state data bus |

## Verification
The assertions run on every cycle and check four things:
- The drive-enable never comes up in standby or without the output gate.
- A program edge leaves the addressed word with no bit set that was clear in the old word or in the input byte.
- A cycle without a write leaves the sampled word unchanged.
- An in-range identifier byte always has odd parity.

The access and gate wait windows are checked against the previous cycle. Only the bench scenarios can show that the right codes appear for each address pattern, that an inhibited chip keeps its contents, and that the output comes up on the exact edge set by `ACC_CYC` and `OE_CYC`.

// File: rtl/otp_emu_pkg.sv
`timescale 1ns/1ps
package otp_emu_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_GATED,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM,
    MODE_INHIBIT
  } otp_mode_e;

  localparam int unsigned BYTE_W = 8;

  // Identifier byte: bit 7 makes the total count of ones odd.
  function automatic logic [BYTE_W-1:0] id_with_parity(input logic [BYTE_W-2:0] base);
    return {~(^base), base};
  endfunction

  // Programming can only clear bits.
  function automatic logic [BYTE_W-1:0] burn_merge(input logic [BYTE_W-1:0] old_word,
                                                   input logic [BYTE_W-1:0] new_word);
    return old_word & new_word;
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
`timescale 1ns/1ps
module otp_mode_dec
  import otp_emu_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      id_hi,
  output otp_mode_e mode,
  output logic      wr_en,
  output logic      out_sel,
  output logic      gate_n
);

  always_comb begin
    if (vpp_hi) begin
      mode = ce_n ? MODE_INHIBIT : MODE_PROGRAM;
    end else if (ce_n) begin
      mode = MODE_STANDBY;
    end else if (oe_n) begin
      mode = MODE_GATED;
    end else if (id_hi) begin
      mode = MODE_IDENT;
    end else begin
      mode = MODE_READ;
    end
  end

  assign wr_en   = (mode == MODE_PROGRAM);
  assign out_sel = (mode == MODE_READ) || (mode == MODE_IDENT);
  // The programming flag occupies the gate pin, so it closes the gate.
  assign gate_n  = oe_n | vpp_hi;

endmodule

// File: rtl/otp_access_timer.sv
`timescale 1ns/1ps
module otp_access_timer #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned ACC_CYC = 4,
  parameter int unsigned OE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              gate_n,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_ready,
  output logic              oe_ready
);

  localparam int unsigned ACC_W = $clog2(ACC_CYC + 1);
  localparam int unsigned OE_W  = $clog2(OE_CYC + 1);
  localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(ACC_CYC);
  localparam logic [OE_W-1:0]  OE_LIM  = OE_W'(OE_CYC);

  logic [ADDR_W-1:0] addr_q;
  logic              id_q;
  logic [ACC_W-1:0]  acc_cnt;
  logic [OE_W-1:0]   oe_cnt;
  logic              key_chg;

  assign key_chg = (addr != addr_q) || (id_hi != id_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      id_q    <= 1'b0;
      acc_cnt <= '0;
    end else begin
      addr_q <= addr;
      id_q   <= id_hi;
      if (ce_n) begin
        acc_cnt <= '0;
      end else if (key_chg) begin
        acc_cnt <= ACC_W'(1);
      end else if (acc_cnt != ACC_LIM) begin
        acc_cnt <= acc_cnt + ACC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_cnt <= '0;
    end else if (gate_n) begin
      oe_cnt <= '0;
    end else if (oe_cnt != OE_LIM) begin
      oe_cnt <= oe_cnt + OE_W'(1);
    end
  end

  assign acc_ready = (acc_cnt == ACC_LIM);
  assign oe_ready  = (oe_cnt == OE_LIM);

  AST_ACC_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !$past(ce_n)); // R10
  AST_ACC_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && ACC_CYC > 1) |-> !$past(key_chg)); // R10
  AST_GATE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    oe_ready |-> !$past(gate_n)); // R11

endmodule

// File: rtl/otp_array.sv
`timescale 1ns/1ps
module otp_array
  import otp_emu_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  assign rd_data = cells[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '1;
      end
    end else if (wr_en) begin
      cells[addr] <= burn_merge(cells[addr], din);
    end
  end

  // Snapshot of the previous cycle for the checks below.
  logic [ADDR_W-1:0] snap_addr;
  logic [BYTE_W-1:0] snap_old;
  logic [BYTE_W-1:0] snap_din;
  logic              snap_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_addr <= '0;
      snap_old  <= '1;
      snap_din  <= '1;
      snap_wr   <= 1'b0;
    end else begin
      snap_addr <= addr;
      snap_old  <= rd_data;
      snap_din  <= din;
      snap_wr   <= wr_en;
    end
  end

  AST_BURN_TAKES_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |-> ((cells[snap_addr] & ~snap_din) == '0)); // R3
  AST_BURN_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |-> ((cells[snap_addr] & ~snap_old) == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_wr |-> (cells[snap_addr] == snap_old)); // R4

endmodule

// File: rtl/otp_id_sel.sv
`timescale 1ns/1ps
module otp_id_sel
  import otp_emu_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 11,
  parameter logic [6:0]      MFR_BASE = 7'h1C,
  parameter logic [6:0]      DEV_BASE = 7'h0C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] id_data,
  output logic              id_clean
);

  localparam logic [BYTE_W-1:0] CONT_CODE = 8'h7F;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'(32'h0000_0203);

  assign id_clean = ((addr & ~KEEP_MASK) == '0);

  always_comb begin
    if (!id_clean) begin
      id_data = '1;
    end else if (!addr[1]) begin
      id_data = CONT_CODE;
    end else if (addr[0]) begin
      id_data = id_with_parity(DEV_BASE);
    end else begin
      id_data = id_with_parity(MFR_BASE);
    end
  end

endmodule

// File: rtl/otp_emu.sv
`timescale 1ns/1ps
module otp_emu
  import otp_emu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned ACC_CYC  = 4,
  parameter int unsigned OE_CYC   = 2,
  parameter logic [6:0]  MFR_BASE = 7'h1C,
  parameter logic [6:0]  DEV_BASE = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  otp_mode_e         mode;
  logic              wr_en;
  logic              out_sel;
  logic              gate_n;
  logic              acc_ready;
  logic              oe_ready;
  logic [BYTE_W-1:0] array_q;
  logic [BYTE_W-1:0] id_q;
  logic              id_clean;

  otp_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .id_hi   (id_hi),
    .mode    (mode),
    .wr_en   (wr_en),
    .out_sel (out_sel),
    .gate_n  (gate_n)
  );

  otp_access_timer #(
    .ADDR_W  (ADDR_W),
    .ACC_CYC (ACC_CYC),
    .OE_CYC  (OE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .gate_n    (gate_n),
    .id_hi     (id_hi),
    .addr      (addr),
    .acc_ready (acc_ready),
    .oe_ready  (oe_ready)
  );

  otp_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .din     (din),
    .rd_data (array_q)
  );

  otp_id_sel #(
    .ADDR_W   (ADDR_W),
    .MFR_BASE (MFR_BASE),
    .DEV_BASE (DEV_BASE)
  ) u_id (
    .addr     (addr),
    .id_data  (id_q),
    .id_clean (id_clean)
  );

  assign dout_en = out_sel && acc_ready && oe_ready;
  assign dout    = (mode == MODE_IDENT) ? id_q : array_q;

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en); // R2
  AST_DRIVE_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!oe_n && !vpp_hi)); // R2
  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && id_hi && id_clean) |-> (^dout)); // R8

endmodule

// File: tb/otp_emu_test.sv
`timescale 1ns/1ps
module otp_emu_test;

  localparam int ADDR_W = 11;
  localparam int ACC    = 4;
  localparam int OEC    = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [6:0] MFR = 7'h1C;
  localparam logic [6:0] DEV = 7'h0C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  otp_emu #(.ADDR_W(ADDR_W), .ACC_CYC(ACC), .OE_CYC(OEC),
            .MFR_BASE(MFR), .DEV_BASE(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  // Identifier value restated: count ones and top up to odd.
  function automatic int ident_of(input int base);
    int ones = 0;
    for (int b = 0; b < 7; b++) ones += (base >> b) & 1;
    return (ones % 2 == 0) ? (base | 128) : base;
  endfunction

  // Behavioural reference model
  int ref_mem [DEPTH];
  int acc_n = 0, oe_cnt_n = 0, last_addr = 0, last_id = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 255;
      acc_n = 0; oe_cnt_n = 0; last_addr = 0; last_id = 0;
    end else begin
      if (ce_n) acc_n = 0;
      else if (int'(addr) != last_addr || int'(id_hi) != last_id) acc_n = 1;
      else if (acc_n < ACC) acc_n++;
      last_addr = int'(addr); last_id = int'(id_hi);
      if (oe_n || vpp_hi) oe_cnt_n = 0;
      else if (oe_cnt_n < OEC) oe_cnt_n++;
      if (vpp_hi && !ce_n) ref_mem[int'(addr)] = ref_mem[int'(addr)] & int'(din);
    end
  end

  function automatic int exp_data();
    int a = int'(addr);
    if (!id_hi) return ref_mem[a];
    if ((a & ~32'h203) != 0) return 255;
    if ((a & 2) == 0) return 127;
    return (a & 1) ? ident_of(int'(DEV)) : ident_of(int'(MFR));
  endfunction

  // Per-cycle comparison, a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      automatic int e_en = (!ce_n && !oe_n && !vpp_hi && acc_n == ACC && oe_cnt_n == OEC) ? 1 : 0;
      checks++;
      if (int'(dout_en) != e_en) begin
        errors++;
        $display("FAIL R10 per-cycle dout_en actual=%0d expected=%0d at %0t", dout_en, e_en, $time);
      end else if (e_en == 1 && int'(dout) != exp_data()) begin
        errors++;
        $display("FAIL R3 per-cycle dout actual=%02h expected=%02h at %0t", dout, exp_data(), $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic o, input logic v, input logic i,
                       input int a, input int d);
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; id_hi = i;
    addr = ADDR_W'(a); din = 8'(d);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: erased contents
    drive(0, 0, 0, 0, 5, 0); settle(ACC);
    chk("R1 enable", int'(dout_en), 1);
    chk("R1 erased word", int'(dout), 8'hFF);

    // R2: standby ignores the output gate
    drive(1, 0, 0, 0, 5, 0); settle(1);
    chk("R2 standby enable", int'(dout_en), 0);
    drive(0, 0, 1, 0, 9, 8'h00); drive(1, 0, 0, 0, 9, 0); settle(1);
    chk("R2 vpp with gate low", int'(dout_en), 0);

    // R3: program then verify
    drive(0, 1, 1, 0, 5, 8'h5A); settle(1);
    drive(0, 0, 0, 0, 5, 0); settle(ACC);
    chk("R3 programmed word", int'(dout), 8'h5A);

    // R5: second program ANDs, zeros stay zero
    drive(0, 1, 1, 0, 5, 8'hF0); settle(1);
    drive(0, 0, 0, 0, 5, 0); settle(ACC);
    chk("R5 re-program", int'(dout), 8'h50);
    drive(0, 1, 1, 0, 5, 8'hFF); settle(1);
    drive(0, 0, 0, 0, 5, 0); settle(ACC);
    chk("R5 ones cannot return", int'(dout), 8'h50);

    // R4: inhibited chip keeps contents
    drive(1, 1, 1, 0, 6, 8'h00); settle(2);
    drive(0, 0, 0, 0, 6, 0); settle(ACC);
    chk("R4 inhibited word", int'(dout), 8'hFF);

    // R10: access window after an address move
    drive(0, 0, 0, 0, 7, 0); settle(ACC - 1);
    chk("R10 not yet valid", int'(dout_en), 0);
    settle(1);
    chk("R10 valid on edge", int'(dout_en), 1);

    // R11: gate window
    drive(0, 1, 0, 0, 7, 0); settle(2);
    drive(0, 0, 0, 0, 7, 0); settle(OEC - 1);
    chk("R11 not yet valid", int'(dout_en), 0);
    settle(1);
    chk("R11 valid on edge", int'(dout_en), 1);

    // R6 / R8: identifier bytes
    drive(0, 0, 0, 1, 2, 0); settle(ACC);
    chk("R6 manufacturer", int'(dout), ident_of(int'(MFR)));
    chk("R8 manufacturer parity", int'($countones(dout)) % 2, 1);
    drive(0, 0, 0, 1, 3, 0); settle(ACC);
    chk("R6 device", int'(dout), ident_of(int'(DEV)));
    chk("R8 device parity", int'($countones(dout)) % 2, 1);
    chk("R8 device top bit", int'(dout[7]), 1);

    // R7: continuation code
    drive(0, 0, 0, 1, 1, 0); settle(ACC);
    chk("R7 continuation", int'(dout), 8'h7F);

    // R9: stray address bits, and bit 9 ignored
    drive(0, 0, 0, 1, 32'h402, 0); settle(ACC);
    chk("R9 stray bit", int'(dout), 8'hFF);
    drive(0, 0, 0, 1, 32'h202, 0); settle(ACC);
    chk("R9 bit 9 ignored", int'(dout), ident_of(int'(MFR)));

    drive(1, 1, 0, 0, 0, 0); settle(2);
    finish_run();
  end

endmodule